// File: doc/BRIEF.md
# Serial Flash Command Slave

This block is the device side of a small serial memory on an SPI link. It runs in SPI mode 0. A frame opens when chip select goes low. The first byte of the frame is the operation code. The next three bytes form a 24-bit pointer, sent most significant byte first. Every byte after that is a data byte. On a data byte the block acts on the latched operation: it writes to or reads from an internal byte array, returns a status byte, or sets or clears the write-enable flag.

The link pins are brought into the system clock domain through synchronizers and sampled there. SCLK must therefore stay low and high for at least four system clocks in each phase. A `keep_cmd` input, sampled when chip select rises, lets a transfer span several frames. While it is high, the operation and the pointer are kept, so the next frame carries on with data bytes. While it is low, the end of the frame sends the block back to waiting for a new operation.

Top module: `spi_flash_slave`

## Requirements
- R1: The first byte of a frame is taken as the operation code and the pointer is cleared. MISO returns 0x00 during the operation byte and during all three pointer bytes.
- R2: Every operation code, known or not, is followed by exactly three pointer bytes, shifted in most significant byte first. The memory is indexed by the low log2(MEM_BYTES) bits of the pointer, and the upper bits are ignored.
- R3: Code 0x02 (store) writes each data byte to the indexed location and then advances the pointer by one. A data byte is written only while the write-enable flag is set. Without the flag the byte is dropped, but the pointer still advances.
- R4: Code 0x03 (fetch) returns the byte at the pointer on each data byte and then advances the pointer. The index wraps from the top of the array to 0. Fetching leaves the status byte unchanged.
- R5: On each data byte, code 0x06 sets the write-enable flag and code 0x04 clears it. The flag is bit 1 of the status byte.
- R6: Code 0x05 returns the status byte on every data byte. Bit 1 is the write-enable flag and all other bits read 0.
- R7: Any other operation code returns 0x00 on its data bytes and changes neither the memory, the pointer nor the flag.
- R8: When chip select rises with `keep_cmd` low, the next byte is parsed as a new operation code. When it rises with `keep_cmd` high, the operation and pointer carry over, and the next frame's first byte is a data byte.
- R9: The block samples MOSI on rising SCLK and changes MISO after falling SCLK, most significant bit first. MISO is low while chip select is high.
- R10: After reset the write-enable flag is clear, MISO is low and the block waits for an operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select, frames a transfer |
| spi_mosi | input | 1 | Serial data from the host |
| keep_cmd | input | 1 | Keep operation and pointer across a chip-select rise |
| spi_miso | output | 1 | Serial data to the host |

## Verification
A pointer that shifts in the wrong order or does not advance shows up on the very next fetched byte. The bench fetches across the top of the array and through a pointer with nonzero upper bits to expose it. A wrong write-enable flag shows up as a stored byte that should have been dropped, or the reverse, and as a wrong status byte on the next status read. A phase machine that loses its place returns nonzero data during pointer bytes, or parses a data byte as an operation code. The bench catches this within one frame, because every operation and pointer byte returned is compared against zero.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam int BYTE_W = 8;
  localparam int WEL_BIT = 1;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  localparam logic [BYTE_W-1:0] OP_STORE  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_FETCH  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WE_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT   = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WE_SET = 8'h06;

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sfl_bit_engine.sv
module sfl_bit_engine
  import spi_flash_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              frame_start,
  output logic              frame_end,
  output logic              miso
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic              cs_n_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rise;
  logic              fall;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      cs_n_d      <= 1'b1;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      byte_done   <= 1'b0;
      rx_byte     <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      sclk_d      <= sclk_s;
      cs_n_d      <= cs_n_s;
      byte_done   <= 1'b0;
      frame_start <= cs_n_d & ~cs_n_s;
      frame_end   <= ~cs_n_d & cs_n_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (cs_n_d) begin
          bit_cnt <= '0;
        end else if (rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh, mosi_s};
          end
        end else if (fall && (bit_cnt != '0)) begin
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
        if (load) tx_sh <= load_byte;
      end
    end
  end

  assign miso = tx_sh[BYTE_W-1];

endmodule

// File: rtl/sfl_ram.sv
module sfl_ram #(
  parameter int DEPTH = 512,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/sfl_cmd_ctrl.sv
module sfl_cmd_ctrl
  import spi_flash_pkg::*;
#(
  parameter int PTR_W = 24,
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              hold,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output phase_t            phase,
  output logic [BYTE_W-1:0] cmd,
  output logic [PTR_W-1:0]  ptr,
  output logic              wel
);

  localparam int PTR_BYTES = PTR_W / BYTE_W;
  localparam int LEFT_W = $clog2(PTR_BYTES + 1);

  logic [LEFT_W-1:0] addr_left;
  logic [PTR_W-1:0]  ptr_shift;
  logic [PTR_W-1:0]  ptr_inc;
  logic [BYTE_W-1:0] status;
  logic              data_byte;
  logic              addr_byte;

  assign ptr_shift = {ptr[PTR_W-BYTE_W-1:0], rx_byte};
  assign ptr_inc   = ptr + 1'b1;
  assign data_byte = byte_done && (phase == PH_DATA);
  assign addr_byte = byte_done && (phase == PH_ADDR);

  always_comb begin
    if (addr_byte)                          ram_addr = ptr_shift[AW-1:0];
    else if (data_byte && cmd == OP_FETCH)  ram_addr = ptr_inc[AW-1:0];
    else                                    ram_addr = ptr[AW-1:0];
  end

  assign ram_we    = data_byte && (cmd == OP_STORE) && wel;
  assign ram_wdata = rx_byte;

  always_comb begin
    status = '0;
    status[WEL_BIT] = wel;
  end

  always_comb begin
    if (phase == PH_DATA && cmd == OP_FETCH)     load_byte = ram_rdata;
    else if (phase == PH_DATA && cmd == OP_STAT) load_byte = status;
    else                                         load_byte = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      cmd       <= '0;
      ptr       <= '0;
      addr_left <= '0;
      wel       <= 1'b0;
      load      <= 1'b0;
    end else begin
      load <= byte_done | frame_start;
      if (frame_end) begin
        if (!hold) begin
          phase <= PH_CMD;
          cmd   <= '0;
        end
      end else if (byte_done) begin
        case (phase)
          PH_CMD: begin
            cmd       <= rx_byte;
            ptr       <= '0;
            addr_left <= LEFT_W'(PTR_BYTES);
            phase     <= PH_ADDR;
          end
          PH_ADDR: begin
            ptr       <= ptr_shift;
            addr_left <= addr_left - 1'b1;
            if (addr_left == LEFT_W'(1)) phase <= PH_DATA;
          end
          PH_DATA: begin
            case (cmd)
              OP_STORE, OP_FETCH: ptr <= ptr_inc;
              OP_WE_SET:          wel <= 1'b1;
              OP_WE_CLR:          wel <= 1'b0;
              default:            ;
            endcase
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
  import spi_flash_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int PTR_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic keep_cmd,
  output logic spi_miso
);

  localparam int AW = $clog2(MEM_BYTES);

  logic [2:0]        pins_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              frame_start;
  logic              frame_end;
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic [AW-1:0]     ram_addr;
  logic              ram_we;
  logic [BYTE_W-1:0] ram_wdata;
  logic [BYTE_W-1:0] ram_rdata;
  phase_t            phase;
  logic [BYTE_W-1:0] cmd;
  logic [PTR_W-1:0]  ptr;
  logic              wel;

  sfl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_cs_n, spi_mosi}),
    .q   (pins_s)
  );

  sfl_bit_engine bits_i (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (pins_s[2]),
    .cs_n_s      (pins_s[1]),
    .mosi_s      (pins_s[0]),
    .load        (load),
    .load_byte   (load_byte),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .miso        (spi_miso)
  );

  sfl_cmd_ctrl #(.PTR_W(PTR_W), .AW(AW)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .hold        (keep_cmd),
    .ram_rdata   (ram_rdata),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .load        (load),
    .load_byte   (load_byte),
    .phase       (phase),
    .cmd         (cmd),
    .ptr         (ptr),
    .wel         (wel)
  );

  sfl_ram #(.DEPTH(MEM_BYTES), .DW(BYTE_W)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/spi_flash_slave_chk.sv
module spi_flash_slave_chk
  import spi_flash_pkg::*;
#(
  parameter int PTR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_done,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              frame_end,
  input logic              keep_cmd,
  input phase_t            phase,
  input logic [BYTE_W-1:0] cmd,
  input logic [PTR_W-1:0]  ptr,
  input logic              wel,
  input logic              ram_we
);

  logic known_op;
  assign known_op = (cmd == OP_STORE) || (cmd == OP_FETCH) || (cmd == OP_WE_CLR) ||
                    (cmd == OP_STAT) || (cmd == OP_WE_SET);

  AST_OPCODE_LATCH: assert property (@(posedge clk) disable iff (rst)
    byte_done && !frame_end && phase == PH_CMD |=>
      cmd == $past(rx_byte) && ptr == '0 && phase == PH_ADDR); // R1

  AST_PTR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    byte_done && !frame_end && phase == PH_ADDR |=>
      ptr[BYTE_W-1:0] == $past(rx_byte) &&
      ptr[PTR_W-1:BYTE_W] == $past(ptr[PTR_W-BYTE_W-1:0])); // R2

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    byte_done && !frame_end && phase == PH_DATA && (cmd == OP_STORE || cmd == OP_FETCH) |=>
      ptr == $past(ptr) + PTR_W'(1)); // R4

  AST_FETCH_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    byte_done && phase == PH_DATA && cmd == OP_FETCH |=> $stable(wel)); // R4

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    byte_done && !frame_end && phase == PH_DATA && cmd == OP_WE_SET |=> wel); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    byte_done && !frame_end && phase == PH_DATA && cmd == OP_WE_CLR |=> !wel); // R5

  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst)
    byte_done && phase == PH_DATA && !known_op |=> $stable(ptr) && $stable(wel)); // R7

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    byte_done && phase == PH_DATA && !known_op |-> !ram_we); // R7

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    frame_end && !keep_cmd |=> phase == PH_CMD); // R8

  AST_FRAME_KEEP: assert property (@(posedge clk) disable iff (rst)
    frame_end && keep_cmd |=> $stable(phase) && $stable(cmd) && $stable(ptr)); // R8

endmodule

bind spi_flash_slave spi_flash_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .frame_end (frame_end),
  .keep_cmd  (keep_cmd),
  .phase     (phase),
  .cmd       (cmd),
  .ptr       (ptr),
  .wel       (wel),
  .ram_we    (ram_we)
);

// File: tb/spi_flash_slave_tb_top.sv
module spi_flash_slave_tb_top;

  localparam int HALF = 8;
  localparam int MEM_BYTES = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic keep = 1'b0;
  logic miso;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_flash_slave #(.MEM_BYTES(MEM_BYTES)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (sclk),
    .spi_cs_n (cs_n),
    .spi_mosi (mosi),
    .keep_cmd (keep),
    .spi_miso (miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // operation byte plus three pointer bytes, all must return zero (R1)
  task automatic header(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    xfer(op, r);           check("R1 op byte", {24'h0, r}, 32'h0);
    xfer(a[23:16], r);     check("R1 ptr byte2", {24'h0, r}, 32'h0);
    xfer(a[15:8], r);      check("R1 ptr byte1", {24'h0, r}, 32'h0);
    xfer(a[7:0], r);       check("R1 ptr byte0", {24'h0, r}, 32'h0);
  endtask

  task automatic simple_op(input logic [7:0] op);
    logic [7:0] r;
    sel(); header(op, 24'h0); xfer(8'h00, r); desel();
  endtask

  task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
    sel(); header(8'h05, 24'h0); xfer(8'h00, s0); xfer(8'h00, s1); desel();
  endtask

  task automatic store(input logic [23:0] a, input int n, input logic [31:0] d);
    logic [7:0] r;
    sel(); header(8'h02, a);
    for (int i = 0; i < n; i++) begin
      xfer(d[31-8*i -: 8], r);
    end
    desel();
  endtask

  task automatic fetch(input logic [23:0] a, input int n, output logic [31:0] q);
    logic [7:0] r;
    q = '0;
    sel(); header(8'h03, a);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, r);
      q[31-8*i -: 8] = r;
    end
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] s0, s1;
    check("R10 miso after reset", {31'h0, miso}, 32'h0);
    read_status(s0, s1);
    check("R10 flag clear after reset", {24'h0, s0}, 32'h0);
  endtask

  task automatic t_flag();
    logic [7:0] s0, s1;
    simple_op(8'h06);
    read_status(s0, s1);
    check("R5 set flag", {24'h0, s0}, 32'h02);
    check("R6 status on every data byte", {24'h0, s1}, 32'h02);
    simple_op(8'h04);
    read_status(s0, s1);
    check("R5 clear flag", {24'h0, s0}, 32'h0);
  endtask

  task automatic t_store_fetch();
    logic [31:0] q;
    logic [7:0] s0, s1;
    simple_op(8'h06);
    store(24'h0001FE, 4, 32'h11223344);
    fetch(24'h0001FE, 4, q);
    check("R3 R4 R9 burst across array top", q, 32'h11223344);
    fetch(24'h000000, 2, q);
    check("R4 wrap to index 0", q, 32'h33440000);
    fetch(24'h0001FF, 1, q);
    check("R2 pointer byte order", q, 32'h22000000);
    fetch(24'hAB0000, 1, q);
    check("R2 upper pointer bits ignored", q, 32'h33000000);
    read_status(s0, s1);
    check("R4 fetch keeps status", {24'h0, s0}, 32'h02);
    check("R9 miso low while deselected", {31'h0, miso}, 32'h0);
  endtask

  task automatic t_locked();
    logic [31:0] q;
    simple_op(8'h06);
    store(24'h000040, 1, 32'hC3000000);
    simple_op(8'h04);
    store(24'h000040, 2, 32'h5A5A0000);
    fetch(24'h000040, 1, q);
    check("R3 store dropped without flag", q, 32'hC3000000);
  endtask

  task automatic t_unknown();
    logic [7:0] r, s0, s1;
    logic [31:0] q;
    simple_op(8'h06);
    sel(); header(8'h9C, 24'h000040);
    xfer(8'h5A, r);
    check("R7 unknown op returns zero", {24'h0, r}, 32'h0);
    desel();
    fetch(24'h000040, 1, q);
    check("R7 memory untouched", q, 32'hC3000000);
    read_status(s0, s1);
    check("R7 flag untouched", {24'h0, s0}, 32'h02);
  endtask

  task automatic t_hold();
    logic [7:0] r, s;
    keep = 1'b1;
    sel(); header(8'h03, 24'h0001FE); desel();
    sel();
    xfer(8'hFF, r);
    check("R8 held fetch continues", {24'h0, r}, 32'h11);
    xfer(8'hFF, r);
    check("R8 held pointer advances", {24'h0, r}, 32'h22);
    keep = 1'b0;
    desel();
    sel();
    header(8'h05, 24'h0);
    xfer(8'h00, s);
    check("R8 new operation after release", {24'h0, s}, 32'h02);
    desel();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_flag();
    t_store_fetch();
    t_locked();
    t_unknown();
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule